// File: doc/BRIEF.md
# Dual-Channel DAC Serial Command Interface

This block is the digital front end of a two-channel, 12-bit converter. A three-wire serial port shifts in 16-bit command words: a clock line, a data line and an active-low select. The port lines are brought into the block's system clock domain, and each word is assembled in a shift register. When the sixteenth bit has arrived, the 4-bit control field is decoded and acted on.

Each channel holds two registers in series. The input register is a staging value. The DAC register drives the converter's output code. Commands can do any of three things:
- write the data straight through to the DAC register;
- stage the data in the input register only;
- copy the staged value into the DAC register.

Each command applies to channel A, channel B or both. One reserved code instead sets or clears a per-channel flag that floats the analog output.

The two DAC codes and the two float flags leave the block as plain outputs for the analog section.

Top module: `dual_dac_cmd`

## Requirements
- R1: After reset both DAC codes, both input registers and both float flags are zero.
- R2: A word is 16 bits, sent most significant bit first. The top 4 bits are the control field (C3..C0) and the low 12 bits are the data. SDI is taken on each falling SCK edge while CS is low, and the command takes effect on the 16th such edge.
- R3: While CS is high, SCK edges are ignored. If CS rises before 16 bits have arrived, the partial word is dropped and no register or flag changes.
- R4: After a word completes, further SCK edges are ignored until CS goes high and then low again. That new low level restarts the bit count.
- R5: Codes 0000 (A), 0001 (B) and 0010 (both) load the data into both the input register and the DAC register of the selected channels.
- R6: Codes 0100 (A), 0101 (B) and 0110 (both) load the data into the input register only. The DAC codes do not change.
- R7: Codes 1000 (A), 1001 (B) and 1010 (both) copy each selected input register into its DAC register.
- R8: Code 1111 is the power-down command. D1 picks the channel (0 = A, 1 = B). D0 = 1 sets that channel's float flag and D0 = 0 clears it. Writing a DAC register does not clear a float flag.
- R9: Every other code (0011, 0111, 1011, 1100, 1101, 1110) changes no register and no flag.
- R10: The DAC codes and float flags change only in the cycle that a complete, valid word is executed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; the port lines are sampled with it |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Serial clock; data is taken on its falling edge |
| sdi | input | 1 | Serial data, most significant bit first |
| cs_n | input | 1 | Active-low select that frames one word |
| code_a | output | 12 | DAC register of channel A |
| code_b | output | 12 | DAC register of channel B |
| float_a | output | 1 | Channel A output is to float |
| float_b | output | 1 | Channel B output is to float |

## Verification
The bench drops CS after 10 and after 15 bits. A design that executed partial words, or counted from the wrong origin, would change a code there.

It also keeps CS low for 32 clocks carrying a different second word. A design that did not lock out after the 16th edge would apply the second word.

Staged values are checked by copying them to the outputs afterwards. This shows whether an input-only load leaked to the DAC register. It also shows whether any of the six unassigned codes corrupted an input register.

Float flags are checked across a later DAC write. A design that cleared them on a data write would be caught, as would one that swapped the channel bit with the float bit.

// File: rtl/dual_dac_cmd.sv
module dual_dac_cmd #(
  parameter int DATA_W      = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck,
  input  logic              sdi,
  input  logic              cs_n,
  output logic [DATA_W-1:0] code_a,
  output logic [DATA_W-1:0] code_b,
  output logic              float_a,
  output logic              float_b
);
  localparam int CTRL_W = 4;
  localparam int WORD_W = DATA_W + CTRL_W;
  localparam int CW     = $clog2(WORD_W + 1);

  logic [SYNC_STAGES-1:0] sck_sr, sdi_sr, cs_sr;
  logic sck_s, sdi_s, cs_s, sck_prev, cs_prev;
  logic armed;
  logic [CW-1:0] cnt;
  logic [WORD_W-2:0] shreg;
  logic [DATA_W-1:0] in_a, in_b;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sck_sr <= '1;
      cs_sr  <= '1;
      sdi_sr <= '0;
    end else begin
      sck_sr <= {sck_sr[SYNC_STAGES-2:0], sck};
      cs_sr  <= {cs_sr[SYNC_STAGES-2:0], cs_n};
      sdi_sr <= {sdi_sr[SYNC_STAGES-2:0], sdi};
    end

  assign sck_s = sck_sr[SYNC_STAGES-1];
  assign cs_s  = cs_sr[SYNC_STAGES-1];
  assign sdi_s = sdi_sr[SYNC_STAGES-1];

  wire sck_fall = sck_prev & ~sck_s;
  wire last     = (cnt == CW'(WORD_W - 1));
  wire fire     = armed & ~cs_s & sck_fall & last;

  wire [WORD_W-1:0] word = {shreg, sdi_s};
  wire [CTRL_W-1:0] ctrl = word[WORD_W-1 -: CTRL_W];
  wire [DATA_W-1:0] data = word[DATA_W-1:0];
  wire [1:0]        act  = ctrl[3:2];
  wire [1:0]        ch   = ctrl[1:0];
  wire hit_a = (ch == 2'b00) || (ch == 2'b10);
  wire hit_b = (ch == 2'b01) || (ch == 2'b10);
  wire pd    = (ctrl == 4'hF);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sck_prev <= 1'b1;
      cs_prev  <= 1'b1;
      armed    <= 1'b0;
      cnt      <= '0;
      shreg    <= '0;
    end else begin
      sck_prev <= sck_s;
      cs_prev  <= cs_s;
      if (cs_s) begin
        armed <= 1'b0;
        cnt   <= '0;
      end else if (cs_prev) begin
        armed <= 1'b1;
        cnt   <= '0;
      end else if (sck_fall && armed) begin
        shreg <= word[WORD_W-2:0];
        if (last) begin
          armed <= 1'b0;
          cnt   <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      in_a    <= '0;
      in_b    <= '0;
      code_a  <= '0;
      code_b  <= '0;
      float_a <= 1'b0;
      float_b <= 1'b0;
    end else if (fire) begin
      if (pd) begin
        if (data[1]) float_b <= data[0];
        else         float_a <= data[0];
      end else if (ch != 2'b11) begin
        case (act)
          2'b00: begin
            if (hit_a) begin in_a <= data; code_a <= data; end
            if (hit_b) begin in_b <= data; code_b <= data; end
          end
          2'b01: begin
            if (hit_a) in_a <= data;
            if (hit_b) in_b <= data;
          end
          2'b10: begin
            if (hit_a) code_a <= in_a;
            if (hit_b) code_b <= in_b;
          end
          default: ;
        endcase
      end
    end

  a_r4_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < CW'(WORD_W));
  a_r3_cs_high_idle: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s |=> (cnt == '0 && !armed));
  a_r10_codes_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> ($stable(code_a) && $stable(code_b)));
  a_r6_stage_keeps_dac: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && act == 2'b01) |=> ($stable(code_a) && $stable(code_b)));
  a_r8_float_only_pd: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !pd) |=> ($stable(float_a) && $stable(float_b)));
  a_r9_bad_code_inert: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !pd && (ch == 2'b11 || act == 2'b11)) |=>
      ($stable(in_a) && $stable(in_b) && $stable(code_a) && $stable(code_b)));
endmodule

// File: tb/dual_dac_cmd_tb.sv
`timescale 1ns/1ps
module dual_dac_cmd_tb;
  logic clk = 0, rst_n = 0, sck = 1, sdi = 0, cs_n = 1;
  logic [11:0] code_a, code_b;
  logic float_a, float_b;
  int n_run = 0, n_fail = 0;
  bit done = 0;
  string tag = "R1";
  int m_in_a = 0, m_in_b = 0, m_da = 0, m_db = 0, m_fa = 0, m_fb = 0;

  always #2.5 clk = ~clk;

  dual_dac_cmd u_dut (.clk(clk), .rst_n(rst_n), .sck(sck), .sdi(sdi), .cs_n(cs_n),
    .code_a(code_a), .code_b(code_b), .float_a(float_a), .float_b(float_b));

  task automatic model(input int w);
    int c = (w >> 12) & 15, d = w & 12'hFFF;
    bit a = (c & 3) == 0 || (c & 3) == 2, b = (c & 3) == 1 || (c & 3) == 2;
    if (c == 15) begin
      if (d & 2) m_fb = d & 1; else m_fa = d & 1;
    end else if ((c & 3) != 3) begin
      if (c >> 2 == 0) begin
        if (a) begin m_in_a = d; m_da = d; end
        if (b) begin m_in_b = d; m_db = d; end
      end else if (c >> 2 == 1) begin
        if (a) m_in_a = d;
        if (b) m_in_b = d;
      end else if (c >> 2 == 2) begin
        if (a) m_da = m_in_a;
        if (b) m_db = m_in_b;
      end
    end
  endtask

  task automatic compare();
    repeat (4) begin
      @(negedge clk);
      n_run++;
      if (code_a !== 12'(m_da) || code_b !== 12'(m_db) ||
          float_a !== 1'(m_fa) || float_b !== 1'(m_fb)) begin
        n_fail++;
        $display("FAIL %s: got a=%h b=%h fa=%b fb=%b expected a=%h b=%h fa=%0d fb=%0d",
                 tag, code_a, code_b, float_a, float_b, m_da, m_db, m_fa, m_fb);
      end
    end
  endtask

  task automatic send(input int w, input int w2, input int nbits, input string t);
    tag = t;
    @(negedge clk);
    cs_n = 0;
    sck = 1;
    repeat (4) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      int src = (i < 16) ? w : w2;
      sdi = 1'((src >> (15 - (i % 16))) & 1);
      repeat (4) @(negedge clk);
      sck = 0;
      repeat (4) @(negedge clk);
      sck = 1;
    end
    repeat (4) @(negedge clk);
    cs_n = 1;
    if (nbits >= 16) model(w);
    repeat (12) @(negedge clk);
    compare();
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    tag = "R1";
    compare();
    send(16'h0ABC, 0, 16, "R5/R2 direct A");
    send(16'h1123, 0, 16, "R5 direct B");
    send(16'h2FFF, 0, 16, "R5 direct both");
    send(16'h2801, 0, 16, "R2 msb-first both");
    send(16'h4555, 0, 16, "R6 stage A");
    send(16'h5AAA, 0, 16, "R6 stage B");
    send(16'h8000, 0, 16, "R7 transfer A");
    send(16'h9000, 0, 16, "R7 transfer B");
    send(16'h6321, 0, 16, "R6 stage both");
    send(16'hA000, 0, 16, "R7 transfer both");
    send(16'h0123, 0, 10, "R3 abort at 10");
    send(16'h1FFF, 0, 15, "R3 abort at 15");
    send(16'hA000, 0, 16, "R3 staged regs intact");
    send(16'h0456, 16'h1FFF, 32, "R4 lockout after 16");
    send(16'h1789, 0, 16, "R4 rearm after CS");
    send(16'hF001, 0, 16, "R8 float A");
    send(16'hF003, 0, 16, "R8 float B");
    send(16'h2111, 0, 16, "R8 write keeps float");
    send(16'hF000, 0, 16, "R8 wake A");
    send(16'hF002, 0, 16, "R8 wake B");
    send(16'h3123, 0, 16, "R9 code 0011");
    send(16'h7456, 0, 16, "R9 code 0111");
    send(16'hB789, 0, 16, "R9 code 1011");
    send(16'hC111, 0, 16, "R9 code 1100");
    send(16'hD222, 0, 16, "R9 code 1101");
    send(16'hE333, 0, 16, "R9 code 1110");
    send(16'hA000, 0, 16, "R9 inputs unchanged");
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule